// File: doc/BRIEF.md
# Staged Configuration Register Bank

A byte-wide register file that holds the control settings of a data converter. A host port carries an 8-bit address, 8-bit write data, a write strobe and a read strobe. A small set of chip-level registers takes new values on the write edge. Most converter settings are staged instead: a host write to one of these goes into a holding copy and changes nothing downstream. A later commit applies every staged value to the active copy, all in one clock.

The active copies drive the converter through a flat output vector. The chip-level registers drive their own vector. A commit starts with a write that sets bit 0 of the transfer address 0xFF. That bit is kept for one clock. In the next clock every holding value is copied into its active register, and the bit then clears itself. Reads return the holding value of a staged register. A debug output returns the active value of the same address, in the same cycle as the read data.

Top module: `shadow_cfg_bank`

## Requirements
- R1: After reset, the holding copy and the active copy both hold the defaults. Register 0x14 is 0x01, register 0x00 is 0x18, and every other register is 0x00. No commit is needed before the defaults drive the outputs.
- R2: Direct registers 0x00, 0x01 and 0x02 take the written value on the clock edge that samples the write. `direct_cfg_o` bits [8i+7:8i] carry register i.
- R3: A write to a staged address (0x08–0x20 except 0x13 and 0x1B, plus 0x3C and 0x3E) updates the value read back from it. It leaves `active_cfg_o` unchanged until a commit.
- R4: A write to 0xFF with bit 0 set starts a commit. On the second clock edge after the write, every active register equals its holding register. A write to 0xFF with bit 0 clear has no effect. `active_cfg_o` slot k, at bits [8k+7:8k], is address 0x08+k for k = 0..24, 0x3C for k = 25 and 0x3E for k = 26.
- R5: The transfer bit clears itself after the commit, so a later read of 0xFF returns 0x00.
- R6: A staged write that falls in the commit clock lands in the holding copy only. The commit copies the holding value that stood before that write.
- R7: Unimplemented addresses ignore writes and read as 0x00. These are 0x03–0x07, 0x13, 0x1B, 0x21–0x3B, 0x3D and 0x3F–0xFE.
- R8: Unused bits store and read as 0. The masks are 0x0F for 0x02, 0x3F for 0x14 and 0x1F for 0x18. Every other implemented register uses all 8 bits.
- R9: `rdata_o` takes the read value on the edge that samples the read strobe and holds it between reads. A read and a write to the same address in one cycle return the value held before the write.
- R10: `dbg_active_o` takes the active value of a staged read address in the same cycle as `rdata_o`. It is 0x00 for any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| dbg_active_o | output | 8 | Registered active value of the staged read address |
| direct_cfg_o | output | 24 | Direct chip-level registers, 0x00 in the low byte |
| active_cfg_o | output | 216 | Active staged registers, one byte per slot |

## Verification
Direct registers and holding copies change on the edge that samples the write. The active copies change on the second edge after the transfer write. Read data and debug data appear on the edge that samples the read strobe. The bench drives its inputs on falling edges and samples on falling edges, so each result is checked in the half cycle after it is due. For the commit, the active vector is checked once after the first edge, where it must still be unchanged, and again after the second edge, where it must hold the new values. For the registered read, the old value is checked just before the sampling edge. A staged write placed in the very next cycle after the transfer write lands exactly on the copy edge, which tests the collision ordering.

// File: rtl/cfg_bank_pkg.sv
`timescale 1ns/1ps
package cfg_bank_pkg;
  localparam int DW        = 8;
  localparam int AW        = 8;
  localparam int N_DIRECT  = 3;
  localparam int SPAN_LO   = 'h08;
  localparam int SPAN_N    = 25;
  localparam int N_SHADOW  = SPAN_N + 2;
  localparam int SLOT_W    = $clog2(N_SHADOW);
  localparam int DIR_IW    = $clog2(N_DIRECT);
  localparam logic [AW-1:0] XFER_ADDR = 8'hFF;
  localparam int XFER_BIT  = 0;

  typedef enum logic [1:0] {KIND_NONE, KIND_DIRECT, KIND_SHADOW, KIND_XFER} reg_kind_e;

  typedef struct packed {
    reg_kind_e         kind;
    logic [SLOT_W-1:0] idx;
  } reg_sel_t;

  function automatic logic [AW-1:0] slot_addr(int i);
    if (i < SPAN_N) return AW'(SPAN_LO + i);
    else if (i == SPAN_N) return 8'h3C;
    else return 8'h3E;
  endfunction

  function automatic logic [DW-1:0] slot_mask(int i);
    case (slot_addr(i))
      8'h13, 8'h1B: return 8'h00;
      8'h14:        return 8'h3F;
      8'h18:        return 8'h1F;
      default:      return 8'hFF;
    endcase
  endfunction

  function automatic logic [DW-1:0] slot_default(int i);
    return (slot_addr(i) == 8'h14) ? 8'h01 : 8'h00;
  endfunction

  function automatic logic [DW-1:0] direct_mask(int i);
    return (i == 2) ? 8'h0F : 8'hFF;
  endfunction

  function automatic logic [DW-1:0] direct_default(int i);
    return (i == 0) ? 8'h18 : 8'h00;
  endfunction
endpackage

// File: rtl/cfg_bank_decode.sv
`timescale 1ns/1ps
module cfg_bank_decode
  import cfg_bank_pkg::*;
(
  input  logic [AW-1:0] addr_i,
  output reg_sel_t      sel_o
);
  always_comb begin
    sel_o = '{kind: KIND_NONE, idx: '0};
    if (addr_i == XFER_ADDR) sel_o.kind = KIND_XFER;
    for (int i = 0; i < N_DIRECT; i++) begin
      if (addr_i == AW'(i)) begin
        sel_o.kind = KIND_DIRECT;
        sel_o.idx  = SLOT_W'(i);
      end
    end
    for (int i = 0; i < N_SHADOW; i++) begin
      if (addr_i == slot_addr(i) && slot_mask(i) != '0) begin
        sel_o.kind = KIND_SHADOW;
        sel_o.idx  = SLOT_W'(i);
      end
    end
  end
endmodule

// File: rtl/cfg_bank_direct_reg.sv
`timescale 1ns/1ps
module cfg_bank_direct_reg #(
  parameter int          W     = 8,
  parameter logic [W-1:0] RST  = '0,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST & MASK;
    else if (we_i) q_o <= wdata_i & MASK;
  end
endmodule

// File: rtl/cfg_bank_shadow_reg.sv
`timescale 1ns/1ps
module cfg_bank_shadow_reg #(
  parameter int           W    = 8,
  parameter logic [W-1:0] RST  = '0,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic         xfer_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] hold_o,
  output logic [W-1:0] active_o
);
  // copy uses the pre-write holding value on a colliding edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_o   <= RST & MASK;
      active_o <= RST & MASK;
    end else begin
      if (we_i)   hold_o   <= wdata_i & MASK;
      if (xfer_i) active_o <= hold_o;
    end
  end
endmodule

// File: rtl/shadow_cfg_bank.sv
`timescale 1ns/1ps
module shadow_cfg_bank
  import cfg_bank_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic                   rd_en_i,
  input  logic [AW-1:0]          addr_i,
  input  logic [DW-1:0]          wdata_i,
  output logic [DW-1:0]          rdata_o,
  output logic [DW-1:0]          dbg_active_o,
  output logic [N_DIRECT*DW-1:0] direct_cfg_o,
  output logic [N_SHADOW*DW-1:0] active_cfg_o
);
  reg_sel_t             sel;
  logic                 xfer_q;
  logic [DW-1:0]        direct_q [N_DIRECT];
  logic [DW-1:0]        hold_q   [N_SHADOW];
  logic [DW-1:0]        act_q    [N_SHADOW];
  logic [N_SHADOW*DW-1:0] hold_flat;
  logic [DW-1:0]        rd_val, dbg_val;

  cfg_bank_decode u_dec (.addr_i(addr_i), .sel_o(sel));

  for (genvar g = 0; g < N_DIRECT; g++) begin : g_direct
    cfg_bank_direct_reg #(
      .W(DW), .RST(direct_default(g)), .MASK(direct_mask(g))
    ) u_reg (
      .clk_i, .rst_ni,
      .we_i   (wr_en_i && sel.kind == KIND_DIRECT && sel.idx == SLOT_W'(g)),
      .wdata_i(wdata_i),
      .q_o    (direct_q[g])
    );
    assign direct_cfg_o[g*DW +: DW] = direct_q[g];
  end

  for (genvar g = 0; g < N_SHADOW; g++) begin : g_shadow
    cfg_bank_shadow_reg #(
      .W(DW), .RST(slot_default(g)), .MASK(slot_mask(g))
    ) u_reg (
      .clk_i, .rst_ni,
      .we_i    (wr_en_i && sel.kind == KIND_SHADOW && sel.idx == SLOT_W'(g)),
      .xfer_i  (xfer_q),
      .wdata_i (wdata_i),
      .hold_o  (hold_q[g]),
      .active_o(act_q[g])
    );
    assign active_cfg_o[g*DW +: DW] = act_q[g];
    assign hold_flat[g*DW +: DW]    = hold_q[g];
  end

  // transfer bit lives one clock, then clears
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) xfer_q <= 1'b0;
    else         xfer_q <= wr_en_i && sel.kind == KIND_XFER && wdata_i[XFER_BIT];
  end

  always_comb begin
    rd_val  = '0;
    dbg_val = '0;
    unique case (sel.kind)
      KIND_DIRECT: rd_val = direct_q[sel.idx[DIR_IW-1:0]];
      KIND_SHADOW: begin
        rd_val  = hold_q[sel.idx];
        dbg_val = act_q[sel.idx];
      end
      KIND_XFER:   rd_val[XFER_BIT] = xfer_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o      <= '0;
      dbg_active_o <= '0;
    end else if (rd_en_i) begin
      rdata_o      <= rd_val;
      dbg_active_o <= dbg_val;
    end
  end
endmodule

// File: rtl/shadow_cfg_bank_chk.sv
`timescale 1ns/1ps
module shadow_cfg_bank_chk
  import cfg_bank_pkg::*;
(
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   wr_en_i,
  input logic                   rd_en_i,
  input logic [AW-1:0]          addr_i,
  input logic [DW-1:0]          wdata_i,
  input logic [DW-1:0]          rdata_o,
  input logic [DW-1:0]          dbg_active_o,
  input logic [N_DIRECT*DW-1:0] direct_cfg_o,
  input logic [N_SHADOW*DW-1:0] active_cfg_o,
  input logic                   xfer_q,
  input logic [N_SHADOW*DW-1:0] hold_flat
);
  logic unimpl_addr;
  logic shadow_addr;
  assign unimpl_addr = (addr_i >= 8'h03 && addr_i <= 8'h07) || addr_i == 8'h13 ||
                       addr_i == 8'h1B || (addr_i >= 8'h21 && addr_i <= 8'h3B) ||
                       addr_i == 8'h3D || (addr_i >= 8'h3F && addr_i <= 8'hFE);
  assign shadow_addr = ((addr_i >= 8'h08 && addr_i <= 8'h20) && addr_i != 8'h13 &&
                        addr_i != 8'h1B) || addr_i == 8'h3C || addr_i == 8'h3E;

  AST_DIRECT_IMMEDIATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == 8'h00 |=> direct_cfg_o[DW-1:0] == $past(wdata_i)); // R2

  AST_ACTIVE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_q |=> $stable(active_cfg_o)); // R3

  AST_COMMIT_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_q |=> active_cfg_o == $past(hold_flat)); // R4

  AST_XFER_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_q && !(wr_en_i && addr_i == 8'hFF && wdata_i[0]) |=> !xfer_q); // R5

  AST_UNIMPL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && unimpl_addr |=> rdata_o == '0); // R7

  AST_MASKED_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_cfg_o[16*DW+5 +: 3] == '0 && active_cfg_o[12*DW+6 +: 2] == '0); // R8

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o) && $stable(dbg_active_o)); // R9

  AST_DBG_NONSHADOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && !shadow_addr |=> dbg_active_o == '0); // R10
endmodule

bind shadow_cfg_bank shadow_cfg_bank_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .rd_en_i     (rd_en_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .dbg_active_o(dbg_active_o),
  .direct_cfg_o(direct_cfg_o),
  .active_cfg_o(active_cfg_o),
  .xfer_q      (xfer_q),
  .hold_flat   (hold_flat)
);

// File: tb/shadow_cfg_bank_tb.sv
`timescale 1ns/1ps
module shadow_cfg_bank_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]   addr = '0, wdata = '0;
  logic [7:0]   rdata, dbg;
  logic [23:0]  direct;
  logic [215:0] active;
  int           n_chk = 0, n_fail = 0;

  localparam logic [215:0] RST_ACT = 216'h01 << (12*8);

  always #2 clk = ~clk;

  shadow_cfg_bank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .dbg_active_o(dbg),
    .direct_cfg_o(direct), .active_cfg_o(active)
  );

  function automatic int slot_of(logic [7:0] a);
    if (a == 8'h3C) return 25;
    if (a == 8'h3E) return 26;
    return int'(a) - 8;
  endfunction

  function automatic logic [7:0] act(logic [7:0] a);
    return active[slot_of(a)*8 +: 8];
  endfunction

  task automatic chk(string req, logic [255:0] got, logic [255:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // called at a falling edge, returns at the next falling edge
  task automatic wr(logic [7:0] a, logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] v, output logic [7:0] dv);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata; dv = dbg;
  endtask

  task automatic commit();
    wr(8'hFF, 8'h01);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v, dv;
    chk("R1 active", 256'(active), 256'(RST_ACT));
    chk("R1 direct", 256'(direct), 256'(24'h000018));
    rd(8'h14, v, dv);
    chk("R1 read 0x14", 256'(v), 256'(8'h01));
    chk("R10 dbg 0x14", 256'(dv), 256'(8'h01));
    rd(8'h00, v, dv);
    chk("R1 read 0x00", 256'(v), 256'(8'h18));
    chk("R10 dbg direct", 256'(dv), 256'(0));
  endtask

  task automatic t_direct();
    logic [7:0] v, dv;
    wr(8'h01, 8'hA5);
    chk("R2 direct 0x01", 256'(direct), 256'(24'h00A518));
    wr(8'h02, 8'hFF);
    chk("R8 direct 0x02 mask", 256'(direct[23:16]), 256'(8'h0F));
    rd(8'h02, v, dv);
    chk("R8 read 0x02", 256'(v), 256'(8'h0F));
  endtask

  task automatic t_shadow_hold();
    logic [7:0] v, dv;
    wr(8'h08, 8'h5A); wr(8'h3E, 8'hC3); wr(8'h20, 8'h77);
    rd(8'h08, v, dv);
    chk("R3 hold 0x08", 256'(v), 256'(8'h5A));
    chk("R10 dbg before commit", 256'(dv), 256'(0));
    rd(8'h3E, v, dv);
    chk("R3 hold 0x3E", 256'(v), 256'(8'hC3));
    chk("R3 active unchanged", 256'(active), 256'(RST_ACT));
    wr(8'hFF, 8'h00);
    @(negedge clk); @(negedge clk);
    chk("R4 bit0 clear no commit", 256'(active), 256'(RST_ACT));
  endtask

  task automatic t_transfer();
    logic [7:0] v, dv;
    wr(8'hFF, 8'h01);
    chk("R4 not yet after first edge", 256'(active), 256'(RST_ACT));
    @(negedge clk);
    chk("R4 act 0x08", 256'(act(8'h08)), 256'(8'h5A));
    chk("R4 act 0x3E", 256'(act(8'h3E)), 256'(8'hC3));
    chk("R4 act 0x20", 256'(act(8'h20)), 256'(8'h77));
    chk("R4 act 0x14", 256'(act(8'h14)), 256'(8'h01));
    rd(8'hFF, v, dv);
    chk("R5 transfer self clear", 256'(v), 256'(0));
    rd(8'h08, v, dv);
    chk("R10 dbg after commit", 256'(dv), 256'(8'h5A));
  endtask

  task automatic t_unused_bits();
    logic [7:0] v, dv;
    wr(8'h18, 8'hFF);
    rd(8'h18, v, dv);
    chk("R8 read 0x18", 256'(v), 256'(8'h1F));
    wr(8'h14, 8'hFF);
    rd(8'h14, v, dv);
    chk("R8 read 0x14", 256'(v), 256'(8'h3F));
    commit();
    chk("R8 act 0x18", 256'(act(8'h18)), 256'(8'h1F));
    chk("R8 act 0x14", 256'(act(8'h14)), 256'(8'h3F));
  endtask

  task automatic t_unimpl();
    logic [7:0] v, dv;
    logic [7:0] list [8] = '{8'h03, 8'h07, 8'h13, 8'h1B, 8'h21, 8'h3D, 8'h80, 8'hFE};
    for (int i = 0; i < 8; i++) begin
      wr(list[i], 8'hFF);
      rd(list[i], v, dv);
      chk($sformatf("R7 read 0x%0h", list[i]), 256'(v), 256'(0));
    end
    commit();
    chk("R7 act 0x13", 256'(act(8'h13)), 256'(0));
    chk("R7 act 0x1B", 256'(act(8'h1B)), 256'(0));
    chk("R7 direct untouched", 256'(direct), 256'(24'h0FA518));
  endtask

  task automatic t_collision();
    logic [7:0] v, dv;
    wr(8'h0A, 8'h11);
    commit();
    chk("R6 setup act 0x0A", 256'(act(8'h0A)), 256'(8'h11));
    wr(8'h0A, 8'h22);
    wr(8'hFF, 8'h01);
    wr(8'h0A, 8'h33);   // lands on the copy edge
    chk("R6 active takes pre-write", 256'(act(8'h0A)), 256'(8'h22));
    @(negedge clk); @(negedge clk);
    chk("R6 active stays", 256'(act(8'h0A)), 256'(8'h22));
    rd(8'h0A, v, dv);
    chk("R6 holding has new", 256'(v), 256'(8'h33));
  endtask

  task automatic t_read_timing();
    logic [7:0] v, dv;
    rd(8'h08, v, dv);
    chk("R9 read 0x08", 256'(v), 256'(8'h5A));
    rd_en = 1'b1; addr = 8'h20;
    #1;
    chk("R9 not before edge", 256'(rdata), 256'(8'h5A));
    @(negedge clk);
    rd_en = 1'b0;
    chk("R9 after edge", 256'(rdata), 256'(8'h77));
    @(negedge clk); @(negedge clk);
    chk("R9 held while idle", 256'(rdata), 256'(8'h77));
    rd_en = 1'b1; wr_en = 1'b1; addr = 8'h09; wdata = 8'h44;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    chk("R9 read during write", 256'(rdata), 256'(8'h00));
    rd(8'h09, v, dv);
    chk("R9 read after write", 256'(v), 256'(8'h44));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direct();
    t_shadow_hold();
    t_transfer();
    t_unused_bits();
    t_unimpl();
    t_collision();
    t_read_timing();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule